// File: doc/BRIEF.md
# Mode-Banked Register File Switch

This block is the architectural register file of a processor core that has several privileged operating modes. It holds sixteen general registers (r0 to r15) and one saved status register. Register r13 (stack pointer), r14 (link register) and the saved status register each have one shadow copy per register bank. The fast-interrupt mode also has its own copy of r8 to r12. When a mode-change request names a new mode, all the banked copies are exchanged on one clock edge. From then on the visible stack pointer, link register, saved status and, where it applies, the upper general registers belong to the new mode.

The surrounding pipeline reads through two combinational read ports and writes through one general-register write port and one saved-status write port. A mode change is requested with a pulse and a 5-bit target mode code. If the code matches no bank, the request is refused and a one-cycle error flag is raised. Instruction decode, arithmetic and exception vectoring belong to other blocks.

Top module: `mode_bank_rf`

## Requirements
- R1: After reset the current mode is supervisor (5'h13), every general register and the saved status read 0, and the error flag is 0.
- R2: A write with `wrEn` high stores `wrData` into register `wrAddr` of the active view at the clock edge. Both read ports return it from the next cycle on. Reads are combinational from stored state, so a write in the same cycle is not forwarded.
- R3: Mode codes map to banks as follows: 5'h10 user and 5'h1F system share bank 0, 5'h13 supervisor uses bank 1, 5'h17 abort bank 2, 5'h1B undefined bank 3, 5'h12 interrupt bank 4 and 5'h11 fast interrupt bank 5. Moving between user and system therefore keeps r13, r14 and the saved status.
- R4: A request whose target equals the current mode changes no register and does not raise the error flag.
- R5: On a real switch, r13, r14 and the saved status are stored into the old mode's bank and loaded from the new mode's bank on the same edge. Reads in the next cycle see the new mode's copies and `curMode` shows the new code.
- R6: Entering fast-interrupt mode from any other mode stores the current r8 to r12 into the user shadow set and loads the fast-interrupt copies.
- R7: Leaving fast-interrupt mode stores the current r8 to r12 into the fast-interrupt shadow set and restores the user copies.
- R8: A switch between two modes that are not fast interrupt leaves r0 to r12 and r15 unchanged. r0 to r7 and r15 are never banked in any mode.
- R9: A request whose code is not in the R3 list raises `modeErr` for exactly the cycle after the request edge. It leaves the mode and all registers unchanged. Without a request, `modeErr` is 0.
- R10: When a register write or a saved-status write falls in the same cycle as a switch, the write lands in the old mode's copy before banking. This holds for r8 to r14 and the saved status alike.
- R11: A write with `spsrWrEn` high stores `spsrWrData` into the active mode's saved status. `spsrRdData` shows it from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| switchReq | input | 1 | Mode-change request pulse |
| switchMode | input | 5 | Target mode code |
| wrEn | input | 1 | General-register write enable |
| wrAddr | input | 4 | General-register write index |
| wrData | input | DATA_W | General-register write data |
| spsrWrEn | input | 1 | Saved-status write enable |
| spsrWrData | input | DATA_W | Saved-status write data |
| rdAddrA | input | 4 | Read port A index |
| rdDataA | output | DATA_W | Read port A data |
| rdAddrB | input | 4 | Read port B index |
| rdDataB | output | DATA_W | Read port B data |
| spsrRdData | output | DATA_W | Active saved status |
| curMode | output | 5 | Current mode code |
| modeErr | output | 1 | Invalid-mode error pulse |

## Verification
A register write and a mode switch can fall in the same cycle, and then the order of the two decides which bank keeps the written value. The bench drives writes to r8 to r14 and to the saved status together with switches that enter fast interrupt, leave it, or move between user and system, which share a bank. It also mixes the two at random. A behavioural model, in which each bank keeps its own context and the visible view is only selected by mode, applies the write to the old mode first. Every clock the bench sweeps all sixteen registers, the saved status, the mode and the error flag, so a write that lands in the wrong bank shows up after the next switch back.

// File: rtl/mode_bank_pkg.sv
package mode_bank_pkg;
  localparam int MODE_W    = 5;
  localparam int NUM_BANKS = 6;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int NUM_REGS  = 16;
  localparam int ADDR_W    = $clog2(NUM_REGS);
  localparam int HI_BASE   = 8;
  localparam int HI_CNT    = 5;
  localparam int SP_IDX    = 13;
  localparam int LR_IDX    = 14;

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

  localparam logic [BANK_W-1:0] BANK_FIQ = 3'd5;

  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic              doSwitch;
    logic [BANK_W-1:0] oldBank;
    logic [BANK_W-1:0] newBank;
    logic              enterFiq;
    logic              leaveFiq;
  } swStrobe_t;

  function automatic logic modeValid(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_SYS, MODE_SVC, MODE_ABT,
      MODE_UND, MODE_IRQ, MODE_FIQ: modeValid = 1'b1;
      default:                      modeValid = 1'b0;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] modeBank(input logic [MODE_W-1:0] m);
    case (m)
      MODE_SVC: modeBank = 3'd1;
      MODE_ABT: modeBank = 3'd2;
      MODE_UND: modeBank = 3'd3;
      MODE_IRQ: modeBank = 3'd4;
      MODE_FIQ: modeBank = 3'd5;
      default:  modeBank = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/mode_bank_ctrl.sv
module mode_bank_ctrl
  import mode_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              switchReq,
  input  logic [MODE_W-1:0] switchMode,
  output logic [MODE_W-1:0] curMode,
  output logic              modeErr,
  output swStrobe_t         strobe
);
  logic [MODE_W-1:0] modeQ;
  logic              errQ;
  logic              tgtOk;

  always_comb begin
    tgtOk           = modeValid(switchMode);
    strobe          = '0;
    strobe.doSwitch = switchReq && tgtOk && (switchMode != modeQ);
    strobe.oldBank  = modeBank(modeQ);
    strobe.newBank  = modeBank(switchMode);
    strobe.enterFiq = strobe.doSwitch && (strobe.newBank == BANK_FIQ);
    strobe.leaveFiq = strobe.doSwitch && (strobe.oldBank == BANK_FIQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_SVC;
      errQ  <= 1'b0;
    end else begin
      errQ <= switchReq && !tgtOk;
      if (strobe.doSwitch) modeQ <= switchMode;
    end
  end

  assign curMode = modeQ;
  assign modeErr = errQ;
endmodule

// File: rtl/mode_bank_dp.sv
module mode_bank_dp
  import mode_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  swStrobe_t         strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              spsrWrEn,
  input  logic [DATA_W-1:0] spsrWrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] spsrRdData
);
  logic [DATA_W-1:0] gpr     [NUM_REGS];
  logic [DATA_W-1:0] effGpr  [NUM_REGS];
  logic [DATA_W-1:0] spsrQ, effSpsr;
  logic [DATA_W-1:0] bankSp  [NUM_BANKS];
  logic [DATA_W-1:0] bankLr  [NUM_BANKS];
  logic [DATA_W-1:0] bankSr  [NUM_BANKS];
  logic [DATA_W-1:0] usrHi   [HI_CNT];
  logic [DATA_W-1:0] fiqHi   [HI_CNT];
  logic              sameBank;

  // Pending writes applied first, so banking stores the old mode's new value
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      effGpr[i] = (wrEn && (wrAddr == ADDR_W'(i))) ? wrData : gpr[i];
    effSpsr  = spsrWrEn ? spsrWrData : spsrQ;
    sameBank = (strobe.newBank == strobe.oldBank);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++)  gpr[i] <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        bankSp[b] <= '0;
        bankLr[b] <= '0;
        bankSr[b] <= '0;
      end
      for (int k = 0; k < HI_CNT; k++) begin
        usrHi[k] <= '0;
        fiqHi[k] <= '0;
      end
      spsrQ <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) gpr[i] <= effGpr[i];
      spsrQ <= effSpsr;
      if (strobe.doSwitch) begin
        bankSp[strobe.oldBank] <= effGpr[SP_IDX];
        bankLr[strobe.oldBank] <= effGpr[LR_IDX];
        bankSr[strobe.oldBank] <= effSpsr;
        gpr[SP_IDX] <= sameBank ? effGpr[SP_IDX] : bankSp[strobe.newBank];
        gpr[LR_IDX] <= sameBank ? effGpr[LR_IDX] : bankLr[strobe.newBank];
        spsrQ       <= sameBank ? effSpsr        : bankSr[strobe.newBank];
        for (int k = 0; k < HI_CNT; k++) begin
          if (strobe.enterFiq) begin
            usrHi[k]         <= effGpr[HI_BASE+k];
            gpr[HI_BASE+k]   <= fiqHi[k];
          end
          if (strobe.leaveFiq) begin
            fiqHi[k]         <= effGpr[HI_BASE+k];
            gpr[HI_BASE+k]   <= usrHi[k];
          end
        end
      end
    end
  end

  assign rdDataA    = gpr[rdAddrA];
  assign rdDataB    = gpr[rdAddrB];
  assign spsrRdData = spsrQ;
endmodule

// File: rtl/mode_bank_rf.sv
module mode_bank_rf
  import mode_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              switchReq,
  input  logic [4:0]        switchMode,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              spsrWrEn,
  input  logic [DATA_W-1:0] spsrWrData,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] spsrRdData,
  output logic [4:0]        curMode,
  output logic              modeErr
);
  swStrobe_t strobe;

  mode_bank_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .switchReq (switchReq),
    .switchMode(switchMode),
    .curMode   (curMode),
    .modeErr   (modeErr),
    .strobe    (strobe)
  );

  mode_bank_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .spsrWrEn  (spsrWrEn),
    .spsrWrData(spsrWrData),
    .rdAddrA   (rdAddrA),
    .rdAddrB   (rdAddrB),
    .rdDataA   (rdDataA),
    .rdDataB   (rdDataB),
    .spsrRdData(spsrRdData)
  );
endmodule

// File: rtl/mode_bank_rf_chk.sv
module mode_bank_rf_chk
  import mode_bank_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       switchReq,
  input logic [4:0] switchMode,
  input logic [4:0] curMode,
  input logic       modeErr
);
  assert_switch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (switchReq && modeValid(switchMode) && switchMode != curMode)
      |=> (curMode == $past(switchMode)) && !modeErr);

  assert_same_mode_R4: assert property (@(posedge clk) disable iff (!rstN)
    (switchReq && switchMode == curMode) |=> $stable(curMode) && !modeErr);

  assert_bad_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    (switchReq && !modeValid(switchMode)) |=> modeErr && $stable(curMode));

  assert_no_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    !switchReq |=> !modeErr && $stable(curMode));

  assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    modeValid(curMode));
endmodule

bind mode_bank_rf mode_bank_rf_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .switchReq (switchReq),
  .switchMode(switchMode),
  .curMode   (curMode),
  .modeErr   (modeErr)
);

// File: tb/mode_bank_rf_bench.sv
`timescale 1ns/1ps
module mode_bank_rf_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        switchReq = 1'b0;
  logic [4:0]  switchMode = 5'h13;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        spsrWrEn = 1'b0;
  logic [31:0] spsrWrData = '0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0;
  logic [31:0] rdDataA, rdDataB, spsrRdData;
  logic [4:0]  curMode;
  logic        modeErr;

  always #2.5 clk = ~clk;

  mode_bank_rf u_mode_bank_rf (.*);

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  string curTag = "R1";

  // Reference model: one context per bank, visible view selected by mode
  logic [31:0] mLo [16];
  logic [31:0] mHi [2][5];
  logic [31:0] mSp [6], mLr [6], mSr [6];
  logic [4:0]  mMode;
  logic        mErr;

  function automatic int bankOf(input logic [4:0] m);
    case (m)
      5'h10, 5'h1F: return 0;
      5'h13: return 1;
      5'h17: return 2;
      5'h1B: return 3;
      5'h12: return 4;
      5'h11: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] expReg(input int r);
    int b = bankOf(mMode);
    if (r == 13) return mSp[b];
    if (r == 14) return mLr[b];
    if (r >= 8 && r <= 12) return mHi[(mMode == 5'h11) ? 1 : 0][r-8];
    return mLo[r];
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mLo[i] = '0;
    for (int i = 0; i < 5; i++) begin mHi[0][i] = '0; mHi[1][i] = '0; end
    for (int i = 0; i < 6; i++) begin mSp[i] = '0; mLr[i] = '0; mSr[i] = '0; end
    mMode = 5'h13;
    mErr  = 1'b0;
  endtask

  task automatic modelStep();
    int b = bankOf(mMode);
    int r = int'(wrAddr);
    if (wrEn) begin
      if (r == 13) mSp[b] = wrData;
      else if (r == 14) mLr[b] = wrData;
      else if (r >= 8 && r <= 12) mHi[(mMode == 5'h11) ? 1 : 0][r-8] = wrData;
      else mLo[r] = wrData;
    end
    if (spsrWrEn) mSr[b] = spsrWrData;
    mErr = 1'b0;
    if (switchReq) begin
      if (bankOf(switchMode) < 0) mErr = 1'b1;
      else mMode = switchMode;
    end
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", curTag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("curMode", {27'd0, curMode}, {27'd0, mMode});
    chk("modeErr", {31'd0, modeErr}, {31'd0, mErr});
    chk("spsr", spsrRdData, mSr[bankOf(mMode)]);
    for (int i = 0; i < 16; i++) begin
      rdAddrA = 4'(i);
      rdAddrB = 4'(15 - i);
      #0.1;
      chk($sformatf("portA r%0d", i), rdDataA, expReg(i));
      chk($sformatf("portB r%0d", 15 - i), rdDataB, expReg(15 - i));
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    if (rstN) modelStep();
    @(negedge clk);
    checkAll();
    switchReq = 1'b0;
    wrEn      = 1'b0;
    spsrWrEn  = 1'b0;
  endtask

  task automatic doWrite(input int r, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = 4'(r); wrData = d;
    cycle();
  endtask

  task automatic doSpsr(input logic [31:0] d);
    spsrWrEn = 1'b1; spsrWrData = d;
    cycle();
  endtask

  task automatic doSwitch(input logic [4:0] m);
    switchReq = 1'b1; switchMode = m;
    cycle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    // R1: reset state
    curTag = "R1";
    cycle(); cycle();
    rstN = 1'b1;
    cycle();

    // R2: plain writes, R11: saved status in supervisor
    curTag = "R2";
    for (int i = 0; i < 16; i++) doWrite(i, 32'hA000_0000 + i);
    curTag = "R11";
    doSpsr(32'h5555_0013);

    // R5: bank exchange into interrupt mode and back
    curTag = "R5";
    doSwitch(5'h12);
    doWrite(13, 32'h1111_0D0D); doWrite(14, 32'h1111_0E0E); doSpsr(32'h1111_5555);
    doSwitch(5'h13);
    doSwitch(5'h12);

    // R6 / R7: fast-interrupt shadow of r8..r12
    curTag = "R6";
    doSwitch(5'h11);
    for (int i = 8; i <= 14; i++) doWrite(i, 32'hF100_0000 + i);
    curTag = "R7";
    doSwitch(5'h10);
    doSwitch(5'h11);
    doSwitch(5'h1B);

    // R3: user and system share a bank
    curTag = "R3";
    doSwitch(5'h10);
    doWrite(13, 32'h0BAD_5EED); doSpsr(32'h0000_0010);
    doSwitch(5'h1F);
    doWrite(14, 32'h5151_1414);
    doSwitch(5'h10);

    // R4: same-mode request has no effect
    curTag = "R4";
    doSwitch(5'h10);
    wrEn = 1'b1; wrAddr = 4'd9; wrData = 32'h4444_0909;
    doSwitch(5'h10);

    // R8: non-fast switches leave low and upper general registers alone
    curTag = "R8";
    doSwitch(5'h17); doSwitch(5'h1B); doSwitch(5'h13);

    // R9: illegal codes
    curTag = "R9";
    doSwitch(5'h00); doSwitch(5'h14); doSwitch(5'h1E); doSwitch(5'h18);
    cycle();

    // R10: write in the same cycle as a switch
    curTag = "R10";
    wrEn = 1'b1; wrAddr = 4'd13; wrData = 32'h1010_1313;
    spsrWrEn = 1'b1; spsrWrData = 32'h1010_5050;
    doSwitch(5'h11);
    wrEn = 1'b1; wrAddr = 4'd10; wrData = 32'h1010_0A0A;
    doSwitch(5'h12);
    doSwitch(5'h11);
    doSwitch(5'h13);
    wrEn = 1'b1; wrAddr = 4'd9; wrData = 32'h1010_0909;
    doSwitch(5'h11);
    doSwitch(5'h13);
    doSwitch(5'h10);
    wrEn = 1'b1; wrAddr = 4'd14; wrData = 32'h1010_1414;
    doSwitch(5'h1F);

    // Mixed random traffic: R8 and R10 under arbitrary interleaving
    curTag = "R8";
    for (int n = 0; n < 400; n++) begin
      logic [4:0] modes [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h15};
      wrEn       = ($urandom_range(0, 1) == 1);
      wrAddr     = 4'($urandom_range(0, 15));
      wrData     = $urandom;
      spsrWrEn   = ($urandom_range(0, 3) == 0);
      spsrWrData = $urandom;
      switchReq  = ($urandom_range(0, 2) == 0);
      switchMode = modes[$urandom_range(0, 7)];
      cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule